// File: doc/BRIEF.md
# DMA Channel Enable and Transfer Status Register

This block is the control register through which software turns DMA channels on and off. It has two bus addresses. One accepts writes only. The other returns, on a read, the stored enables together with two live status flags from the block-transfer engine.

A write does not load the register as a whole. The top data bit chooses whether the write sets or clears bits. Every other data bit that is 1 picks a register bit to change, and every data bit that is 0 leaves its register bit alone. This lets separate software agents switch their own channels without a read-modify-write sequence.

The block drives one effective enable per channel, and each of these is gated by a master enable bit. It also passes a priority bit to the bus arbiter. It records whether every output word of the current block-transfer operation has been zero.

Top module: `dmactl_top`

## Requirements
- R1: While reset is asserted and after it is released, all stored bits are 0. Every `ch_en` bit is 0, `xfer_prio` is 0, and the zero flag (read bit 13) is 0.
- R2: A write at `WR_ADDR` with data bit 15 = 1 sets to 1 every stored bit in positions 10..0 whose data bit is 1. Stored bits whose data bit is 0 keep their values.
- R3: A write at `WR_ADDR` with data bit 15 = 0 clears to 0 every stored bit in positions 10..0 whose data bit is 1. Stored bits whose data bit is 0 keep their values.
- R4: Bit 15 is not stored. Read bits 15, 12 and 11 are always 0.
- R5: Data bits 14..11 of a write change nothing. Read bit 14 shows busy and read bit 13 shows the zero flag, whatever was written.
- R6: A write at any address other than `WR_ADDR`, including `RD_ADDR`, changes nothing. `bus_rdata` is all zeros unless `bus_addr` equals `RD_ADDR`.
- R7: Stored bit 9 is the master enable. `ch_en[i]` equals stored bit i AND stored bit 9, for i = 8..0. The channels are bit 8 bitplane, bit 7 coprocessor, bit 6 block-transfer engine, bit 5 sprite, bit 4 disk, and bits 3..0 audio channels 3..0.
- R8: `xfer_prio` equals stored bit 10 and does not depend on the master enable.
- R9: Read bit 14 follows `xfer_busy` combinationally, in the same cycle.
- R10: A cycle with `xfer_start` = 1 sets the zero flag to 1 from the next cycle on.
- R11: After a start, a cycle with `xfer_word_vld` = 1 and a nonzero `xfer_word` clears the zero flag. Zero words do not set it again, and the flag holds its value until the next start.
- R12: A write changes the stored bits and the outputs from the clock edge that samples the write strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| bus_rdata | output | 16 | Read word at `RD_ADDR`, otherwise 0 |
| xfer_busy | input | 1 | Block-transfer engine busy |
| xfer_start | input | 1 | One-cycle pulse at the start of a transfer operation |
| xfer_word_vld | input | 1 | The transfer engine output word is valid |
| xfer_word | input | XFER_W | Transfer engine output word |
| ch_en | output | 9 | Effective channel enables, gated by the master enable |
| xfer_prio | output | 1 | Full-priority request to the bus arbiter |

## Verification
The assertions check on every cycle that a set write or a clear write moves only the selected bits, and that cycles without a write or with only status-bit data leave the stored state alone. They also check that the zero flag rises after each start, falls on a nonzero word and otherwise holds, and that a cleared master enable forces every channel enable low. Only the bench scenarios show the assembled read word: the zero bits at positions 15, 12 and 11, the live busy bit, the address decode for both ports, and that an output stays unchanged until the write edge.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
  localparam int DATA_W     = 16;
  localparam int NCH        = 9;
  localparam int MASTER_BIT = 9;
  localparam int PRIO_BIT   = 10;
  localparam int CTL_W      = PRIO_BIT + 1;
  localparam int ZERO_BIT   = 13;
  localparam int BUSY_BIT   = 14;
  localparam int MODE_BIT   = 15;
  localparam int GAP_W      = ZERO_BIT - CTL_W;

  typedef logic [CTL_W-1:0] ctl_t;
endpackage

// File: rtl/dmactl_rst_sync.sv
module dmactl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dmactl_ctl_reg.sv
module dmactl_ctl_reg
  import dmactl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  input  logic set_mode,
  input  ctl_t bit_sel,
  output ctl_t ctl_q
);
  ctl_t ctl_d;
  logic ctl_en;

  always_comb begin
    ctl_en = wr_fire;
    if (set_mode) ctl_d = ctl_q | bit_sel;
    else          ctl_d = ctl_q & ~bit_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  // R2: selected bits are 1 after a set write
  a_r2_set_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && set_mode) |=> ((ctl_q & $past(bit_sel)) == $past(bit_sel)));

  // R3: selected bits are 0 after a clear write
  a_r3_clear_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !set_mode) |=> ((ctl_q & $past(bit_sel)) == '0));

  // R2, R3: unselected bits keep their values
  a_r2_r3_unselected_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ((ctl_q & ~$past(bit_sel)) == ($past(ctl_q) & ~$past(bit_sel))));

  // R6, R12: no write, no change
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(ctl_q));
endmodule

// File: rtl/dmactl_zero_track.sv
module dmactl_zero_track #(
  parameter int XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              word_vld,
  input  logic [XFER_W-1:0] word,
  output logic              zero_q
);
  logic nz_word;
  logic zero_en;
  logic zero_d;

  always_comb begin
    nz_word = word_vld && (word != '0);
    zero_en = op_start || nz_word;
    zero_d  = op_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       zero_q <= 1'b0;
    else if (zero_en) zero_q <= zero_d;
  end

  a_r10_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> zero_q);

  a_r11_nonzero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && word_vld && word != '0) |=> !zero_q);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && !(word_vld && word != '0)) |=> $stable(zero_q));
endmodule

// File: rtl/dmactl_gate.sv
module dmactl_gate #(
  parameter int NCH = 9
) (
  input  logic           master,
  input  logic [NCH-1:0] ch_req,
  output logic [NCH-1:0] ch_en
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_en[i] = ch_req[i] & master;
  end
endmodule

// File: rtl/dmactl_top.sv
module dmactl_top
  import dmactl_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] WR_ADDR = 8'h4A,
  parameter logic [ADDR_W-1:0] RD_ADDR = 8'h12,
  parameter int                XFER_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 xfer_busy,
  input  logic                 xfer_start,
  input  logic                 xfer_word_vld,
  input  logic [XFER_W-1:0]    xfer_word,
  output logic [NCH-1:0]       ch_en,
  output logic                 xfer_prio
);
  logic        rst_n_s;
  logic        wr_fire;
  logic        rd_hit;
  ctl_t        ctl_q;
  logic        zero_q;
  logic [DATA_W-1:0] rd_word;

  dmactl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    wr_fire = bus_we && (bus_addr == WR_ADDR);
    rd_hit  = (bus_addr == RD_ADDR);
  end

  dmactl_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_fire  (wr_fire),
    .set_mode (bus_wdata[MODE_BIT]),
    .bit_sel  (bus_wdata[CTL_W-1:0]),
    .ctl_q    (ctl_q)
  );

  dmactl_zero_track #(.XFER_W(XFER_W)) u_zero (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .op_start (xfer_start),
    .word_vld (xfer_word_vld),
    .word     (xfer_word),
    .zero_q   (zero_q)
  );

  dmactl_gate #(.NCH(NCH)) u_gate (
    .master (ctl_q[MASTER_BIT]),
    .ch_req (ctl_q[NCH-1:0]),
    .ch_en  (ch_en)
  );

  assign xfer_prio = ctl_q[PRIO_BIT];

  always_comb begin
    rd_word = {1'b0, xfer_busy, zero_q, {GAP_W{1'b0}}, ctl_q};
    bus_rdata = rd_hit ? rd_word : '0;
  end

  // R7: a cleared master enable holds every channel low
  a_r7_master_gate: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctl_q[MASTER_BIT] |-> (ch_en == '0));

  // R5: a write carrying only status or unassigned bits changes nothing
  a_r5_status_unwritable: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_fire && bus_wdata[CTL_W-1:0] == '0 && |bus_wdata[BUSY_BIT:CTL_W]) |=> $stable(ctl_q));
endmodule

// File: tb/dmactl_top_tb_top.sv
`timescale 1ns/1ps
module dmactl_top_tb_top;
  localparam logic [7:0] WR_A = 8'h4A;
  localparam logic [7:0] RD_A = 8'h12;
  localparam logic [7:0] OTHER_A = 8'h33;

  typedef struct {
    logic [15:0] rd;
    logic [8:0]  en;
    logic        prio;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        xfer_busy, xfer_start, xfer_word_vld;
  logic [15:0] xfer_word;
  logic [8:0]  ch_en;
  logic        xfer_prio;

  logic [10:0] m_ctl;
  logic        m_zero;
  exp_t        sb_q[$];
  event        mon_ev;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  dmactl_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_busy(xfer_busy),
    .xfer_start(xfer_start), .xfer_word_vld(xfer_word_vld),
    .xfer_word(xfer_word), .ch_en(ch_en), .xfer_prio(xfer_prio)
  );

  function automatic logic [15:0] model_rd();
    return {1'b0, xfer_busy, m_zero, 2'b00, m_ctl};
  endfunction

  task automatic push_exp(input logic [15:0] rd, input string tag);
    exp_t e;
    e.rd   = rd;
    e.en   = m_ctl[9] ? m_ctl[8:0] : 9'h0;
    e.prio = m_ctl[10];
    e.tag  = tag;
    sb_q.push_back(e);
    -> mon_ev;
    #1;
  endtask

  task automatic check_at(input logic [7:0] a, input string tag);
    bus_addr = a;
    #1;
    push_exp((a == RD_A) ? model_rd() : 16'h0, tag);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 16'h0;
    if (a == WR_A) begin
      if (d[15]) m_ctl = m_ctl | d[10:0];
      else       m_ctl = m_ctl & ~d[10:0];
    end
  endtask

  task automatic xfer_cycle(input logic st, input logic v, input logic [15:0] w);
    @(negedge clk);
    xfer_start = st; xfer_word_vld = v; xfer_word = w;
    @(negedge clk);
    xfer_start = 1'b0; xfer_word_vld = 1'b0; xfer_word = 16'h0;
    if (st) m_zero = 1'b1;
    else if (v && w != 16'h0) m_zero = 1'b0;
  endtask

  // monitor: pops one expected item per sample and compares
  initial begin
    forever begin
      @(mon_ev);
      #0;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if (bus_rdata !== e.rd || ch_en !== e.en || xfer_prio !== e.prio) begin
          n_bad++;
          $display("FAIL %s: rdata=%h ch_en=%h prio=%b expected rdata=%h ch_en=%h prio=%b",
                   e.tag, bus_rdata, ch_en, xfer_prio, e.rd, e.en, e.prio);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_ctl = '0; m_zero = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = RD_A; bus_wdata = '0;
    xfer_busy = 1'b0; xfer_start = 1'b0; xfer_word_vld = 1'b0; xfer_word = '0;
    repeat (3) @(negedge clk);
    check_at(RD_A, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_at(RD_A, "R1 after reset");

    bus_write(WR_A, 16'h81F0);
    check_at(RD_A, "R2 set channels, R7 master off");
    bus_write(WR_A, 16'h8200);
    check_at(RD_A, "R7 master on");

    // R12: nothing changes before the sampling edge
    @(negedge clk);
    bus_addr = WR_A; bus_we = 1'b1; bus_wdata = 16'h8001;
    #1;
    push_exp(16'h0, "R12 before edge");
    @(posedge clk);
    #1;
    m_ctl = m_ctl | 11'h001;
    push_exp(16'h0, "R12 after edge");
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 16'h0;

    bus_write(WR_A, 16'hF80E);
    check_at(RD_A, "R5 status bits in write ignored, R4 bit15 reads 0");
    bus_write(WR_A, 16'hF800);
    check_at(RD_A, "R5 status-only write no change");
    bus_write(WR_A, 16'h0030);
    check_at(RD_A, "R3 clear selected");
    bus_write(WR_A, 16'h0200);
    check_at(RD_A, "R7 master cleared gates channels");
    bus_write(WR_A, 16'h8400);
    check_at(RD_A, "R8 priority without master");
    bus_write(RD_A, 16'hFFFF);
    check_at(RD_A, "R6 write at read address ignored");
    bus_write(OTHER_A, 16'h07FF);
    check_at(RD_A, "R6 write at other address ignored");
    check_at(WR_A, "R6 read at write address is zero");
    check_at(OTHER_A, "R6 read at other address is zero");
    bus_write(WR_A, 16'h8200);
    check_at(RD_A, "R7 master back on");

    xfer_busy = 1'b1;
    check_at(RD_A, "R9 busy visible");
    xfer_busy = 1'b0;
    check_at(RD_A, "R9 busy dropped");

    xfer_cycle(1'b1, 1'b0, 16'h0);
    check_at(RD_A, "R10 start sets zero");
    xfer_cycle(1'b0, 1'b1, 16'h0);
    check_at(RD_A, "R11 zero word keeps flag");
    xfer_cycle(1'b0, 1'b1, 16'h0040);
    check_at(RD_A, "R11 nonzero word clears");
    xfer_cycle(1'b0, 1'b1, 16'h0);
    check_at(RD_A, "R11 cleared flag holds");
    xfer_cycle(1'b0, 1'b0, 16'h1234);
    check_at(RD_A, "R11 invalid word ignored");
    xfer_cycle(1'b1, 1'b0, 16'h0);
    check_at(RD_A, "R10 next start sets again");

    bus_write(WR_A, 16'h07FF);
    check_at(RD_A, "R3 clear all");

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule